// File: doc/BRIEF.md
# Log-Step Parallel Prefix Engine

This block computes the inclusive prefix of `N` words (`N` a power of two) under one of eight associative operators. Each word sits in its own register lane, and every lane acts as a small processor with a fixed index. A start strobe captures all `N` input words and the operator code in one cycle. The engine then runs lg N synchronous rounds. In round `j`, every lane whose index is at least `2^j` combines the value held by the lane `2^j` below it with its own value. All lanes read the values left by the previous round.

The lower-index value is always the left operand, so an operator that is associative but not commutative still gives the correct prefix. When the last round finishes, a one-cycle done pulse marks the result, and the outputs hold it until the next accepted start. A start strobe that arrives during a computation has no effect.

Top module: `prefix_engine`

## Requirements
- R1: After a computation, output lane `i` (bits `i*W +: W` of `data_o`) equals `s0 op s1 op ... op si` for the captured inputs `s` (lane `i` of `data_i`). Lane 0 equals `s0`, and lane 0 never changes during the rounds.
- R2: Operator codes on `op_i`: 0 = addition modulo 2^W, 1 = multiplication modulo 2^W, 2 = unsigned maximum, 3 = unsigned minimum, 4 = bitwise AND, 5 = bitwise OR, 6 = bitwise XOR, 7 = keep-left (`a op b = a`).
- R3: The lower-index operand is always the left operand. Under code 7, every output lane therefore equals input lane 0.
- R4: A start strobe is accepted on a clock edge where the engine is idle. `done_o` is high for exactly one cycle, in the cycle after the lg N-th rising edge that follows the accepting edge.
- R5: A start strobe that arrives while a computation is running is ignored. The running computation keeps its inputs, its result and its done timing.
- R6: Between a done pulse and the next accepted start, `data_o` stays stable and `done_o` stays low.
- R7: While `rst_n` is low, and directly after it is released, all output lanes read zero and `done_o` is low. An asserted reset in the middle of a computation aborts it.
- R8: `data_i` and `op_i` are sampled only on an accepted start. Changing them during a computation has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures inputs and operator when idle |
| op_i | input | 3 | Operator code (see R2) |
| data_i | input | N*W | Input words; lane `i` at bits `i*W +: W` |
| done_o | output | 1 | One-cycle pulse when the prefix result is ready |
| data_o | output | N*W | Prefix results; lane `i` at bits `i*W +: W` |

## Verification
A round counter that skips or repeats a step shows up at the ports as a done pulse that is early or late. A stride chosen from the wrong round shows up as wrong upper lanes in the very next result. An operand-order error stays hidden under the commutative operators, so the keep-left code is run to expose it as lanes that differ from lane 0. A lane updating in a round where its index is below the stride corrupts the low lanes. Every fault of this kind is visible in the first done cycle of the computation that triggers it.

// File: rtl/prefix_pkg.sv
package prefix_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_MAX   = 3'd2,
    OP_MIN   = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_XOR   = 3'd6,
    OP_FIRST = 3'd7
  } op_e;

endpackage

// File: rtl/prefix_round_ctrl.sv
module prefix_round_ctrl #(
  parameter int LG = 3,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          last_round,
  output logic [RW-1:0] round_idx,
  output logic          done
);

  logic          busy_q;
  logic          done_q;
  logic [RW-1:0] round_q;

  assign accept     = start && !busy_q;
  assign busy       = busy_q;
  assign round_idx  = round_q;
  assign last_round = busy_q && (round_q == RW'(LG - 1));
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      round_q <= '0;
    end else begin
      done_q <= last_round;
      if (accept) begin
        busy_q  <= 1'b1;
        round_q <= '0;
      end else if (last_round) begin
        busy_q  <= 1'b0;
        round_q <= '0;
      end else if (busy_q) begin
        round_q <= round_q + RW'(1);
      end
    end
  end

endmodule

// File: rtl/prefix_lane.sv
module prefix_lane
  import prefix_pkg::*;
#(
  parameter int W   = 16,
  parameter int LG  = 3,
  parameter int RW  = 2,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [W-1:0]         load_val,
  input  logic                 step,
  input  op_e                  op,
  input  logic [RW-1:0]        round_idx,
  input  logic [LG-1:0][W-1:0] nbr,
  output logic [W-1:0]         q
);

  function automatic logic [W-1:0] combine(op_e f, logic [W-1:0] lo, logic [W-1:0] hi);
    case (f)
      OP_ADD:   return lo + hi;
      OP_MUL:   return lo * hi;
      OP_MAX:   return (lo > hi) ? lo : hi;
      OP_MIN:   return (lo < hi) ? lo : hi;
      OP_AND:   return lo & hi;
      OP_OR:    return lo | hi;
      OP_XOR:   return lo ^ hi;
      default:  return lo;
    endcase
  endfunction

  logic [W-1:0] partner;
  logic         in_range;
  logic [W-1:0] q_r;

  always_comb begin
    partner  = '0;
    in_range = 1'b0;
    for (int k = 0; k < LG; k++) begin
      if (round_idx == RW'(k)) begin
        partner  = nbr[k];
        in_range = (IDX >= (1 << k));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (load) begin
      q_r <= load_val;
    end else if (step && in_range) begin
      q_r <= combine(op, partner, q_r);
    end
  end

  assign q = q_r;

endmodule

// File: rtl/prefix_engine.sv
module prefix_engine
  import prefix_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [N*W-1:0] data_i,
  output logic         done_o,
  output logic [N*W-1:0] data_o
);

  localparam int LG = (N > 1) ? $clog2(N) : 1;
  localparam int RW = (LG > 1) ? $clog2(LG) : 1;

  logic          accept_w;
  logic          busy_w;
  logic          last_w;
  logic [RW-1:0] round_w;
  op_e           op_q;
  logic [W-1:0]  lane_q [N];

  prefix_round_ctrl #(.LG(LG), .RW(RW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .accept     (accept_w),
    .busy       (busy_w),
    .last_round (last_w),
    .round_idx  (round_w),
    .done       (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_ADD;
    else if (accept_w) op_q <= op_e'(op_i);
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [LG-1:0][W-1:0] nbr;
    for (genvar k = 0; k < LG; k++) begin : g_nbr
      if (i >= (1 << k)) begin : g_src
        assign nbr[k] = lane_q[i - (1 << k)];
      end else begin : g_none
        assign nbr[k] = '0;
      end
    end
    prefix_lane #(.W(W), .LG(LG), .RW(RW), .IDX(i)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept_w),
      .load_val  (data_i[i*W +: W]),
      .step      (busy_w),
      .op        (op_q),
      .round_idx (round_w),
      .nbr       (nbr),
      .q         (lane_q[i])
    );
    assign data_o[i*W +: W] = lane_q[i];
  end

endmodule

// File: rtl/prefix_engine_chk.sv
module prefix_engine_chk #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int RW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           accept,
  input logic           busy,
  input logic           last_round,
  input logic [RW-1:0]  round_idx,
  input logic           done_o,
  input logic [N*W-1:0] data_o
);

  initial begin
    assert_pow2_R1: assert ((N & (N - 1)) == 0 && N >= 2);
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_round) |=> (done_o && !busy));

  assert_accept_begins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && round_idx == '0));

  assert_round_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_round) |=> (busy && round_idx == RW'($past(round_idx) + RW'(1))));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(data_o));

  assert_lane0_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_o[W-1:0]));

  assert_lane1_after_r0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && round_idx != '0) |=> $stable(data_o[2*W-1:W]));

endmodule

bind prefix_engine prefix_engine_chk #(.N(N), .W(W), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .accept     (accept_w),
  .busy       (busy_w),
  .last_round (last_w),
  .round_idx  (round_w),
  .done_o     (done_o),
  .data_o     (data_o)
);

// File: tb/prefix_engine_tb.sv
`timescale 1ns/1ps
module prefix_engine_tb;

  localparam int N  = 8;
  localparam int W  = 16;
  localparam int LG = 3;
  localparam int NV = 9;

  localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [N*W-1:0] T_DAT [NV] = '{
    128'h0001_0002_0003_0004_0005_0006_0007_0008,
    128'hFFFF_8000_8000_0001_0002_0003_0004_0005,
    128'h0002_0003_0001_0005_0007_0002_0100_0003,
    128'h0010_0005_8000_0003_7FFF_FFFE_0001_0000,
    128'h0010_0005_8000_0003_7FFF_FFFE_0001_0000,
    128'hFFFF_FFF0_FF0F_F0FF_0FFF_F7FF_FFFF_FFFE,
    128'h0001_0000_0002_0000_0100_0000_8000_0000,
    128'h1234_5678_9ABC_DEF0_0F0F_F0F0_AAAA_5555,
    128'hBEEF_0001_0002_0003_0004_0005_0006_CAFE
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [2:0]     op_i = 3'd0;
  logic [N*W-1:0] data_i = '0;
  logic           done_o;
  logic [N*W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  prefix_engine #(.N(N), .W(W)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .op_i (op_i),
    .data_i (data_i), .done_o (done_o), .data_o (data_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] ref_op(logic [2:0] f, logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] wide;
    logic [W-1:0] r;
    case (f)
      3'd0: begin wide = {{W{1'b0}}, a} + {{W{1'b0}}, b}; r = wide[W-1:0]; end
      3'd1: begin wide = {{W{1'b0}}, a} * {{W{1'b0}}, b}; r = wide[W-1:0]; end
      3'd2: r = (b >= a) ? b : a;
      3'd3: r = (b <= a) ? b : a;
      3'd4: r = ~(~a | ~b);
      3'd5: r = ~(~a & ~b);
      3'd6: r = (a | b) & ~(a & b);
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic logic [N*W-1:0] ref_prefix(logic [2:0] f, logic [N*W-1:0] d);
    logic [N*W-1:0] p;
    logic [W-1:0] acc;
    acc = d[W-1:0];
    p[W-1:0] = acc;
    for (int i = 1; i < N; i++) begin
      acc = ref_op(f, acc, d[i*W +: W]);
      p[i*W +: W] = acc;
    end
    return p;
  endfunction

  task automatic check(bit ok, string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Starts a computation, optionally pulsing start again / changing inputs while busy.
  task automatic run(logic [2:0] f, logic [N*W-1:0] d, bit disturb, output int lat);
    @(negedge clk);
    start_i = 1'b1; op_i = f; data_i = d;
    @(posedge clk);
    @(negedge clk);
    start_i = disturb; op_i = ~f; data_i = ~d;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [N*W-1:0] exp, held;
    repeat (2) @(negedge clk);
    check(data_o == '0 && !done_o, "R7 reset state", data_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_o == '0 && !done_o, "R7 after release", data_o, '0);

    for (int v = 0; v < NV; v++) begin
      run(T_OP[v], T_DAT[v], 1'b0, lat);
      exp = ref_prefix(T_OP[v], T_DAT[v]);
      check(data_o == exp, (T_OP[v] == 3'd7) ? "R3 operand order" : "R1 R2 prefix", data_o, exp);
      check(lat == LG, "R4 done latency", lat, LG);
    end
    check(data_o[W-1:0] == 16'hCAFE, "R3 lane0 under keep-left", data_o, 16'hCAFE);

    // R4 / R6: done one cycle, outputs held afterwards
    held = data_o;
    @(negedge clk);
    check(!done_o, "R4 done one cycle", done_o, 0);
    op_i = 3'd1; data_i = '1;
    repeat (5) @(negedge clk);
    check(data_o == held && !done_o, "R6 outputs held", data_o, held);

    // R5 + R8: extra start and input changes during a computation
    run(3'd0, T_DAT[0], 1'b1, lat);
    exp = ref_prefix(3'd0, T_DAT[0]);
    check(data_o == exp, "R5 R8 ignored start", data_o, exp);
    check(lat == LG, "R5 timing unchanged", lat, LG);

    // R7: reset mid computation
    @(negedge clk);
    start_i = 1'b1; op_i = 3'd6; data_i = T_DAT[7];
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(data_o == '0 && !done_o, "R7 mid-run reset", data_o, '0);
    rst_n = 1'b1;
    repeat (LG + 2) begin
      @(negedge clk);
      check(!done_o, "R7 no done after abort", done_o, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule